// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external host read and write a bank of 32-bit registers over a four-wire serial link. Every transaction is one fixed 40-bit frame. The host sends a header byte first, most significant bit first. The top bit of that byte chooses between writing and reading, and the lower seven bits select the register. A 32-bit data word follows the header.

The read data for the selected register comes back on the serial output in the data phase of the same frame. This happens on write frames as well as read frames, and the value returned is the one held before any write. The block never needs a second frame to fetch read data.

All serial lines are synchronized into the system clock domain, and edges are detected there. The serial clock therefore has to run well below the system clock. A write reaches the register bank only when a frame closes after exactly 40 serial clock rising edges.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 40 bits. MOSI is sampled on rising SCK, most significant bit first. Frame bit 39 is the direction flag: 1 means write and 0 means read.
- R2: Frame bits 38..32 form the 7-bit register address, which is presented on `regAddr`. The address stays stable for the rest of the frame.
- R3: On a write frame with exactly 40 rising edges, `regWe` pulses high for a single clock after `csN` rises. During that pulse, `regWdata` carries frame bits 31..0 and `regAddr` carries the frame's address.
- R4: A frame closed after fewer than 40 rising edges causes no write, and the addressed register keeps its old value.
- R5: A frame closed after more than 40 rising edges causes no write, and the addressed register keeps its old value.
- R6: A read frame (bit 39 = 0) never asserts `regWe`.
- R7: After the 8th rising edge, each falling SCK edge shifts the next bit of the addressed register onto MISO, starting with bit 31. The host reads the 32 bits at the next 32 rising edges of the same frame. On a write frame, the value returned is the contents before the write.
- R8: MISO is 0 throughout the 8-bit header phase.
- R9: MISO is 0 whenever `csN` is high.
- R10: After reset, `regWe` is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idle low |
| csN | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| regAddr | output | 7 | Register bank address |
| regWe | output | 1 | Register bank write strobe |
| regWdata | output | 32 | Register bank write data |
| regRdata | input | 32 | Register bank read data for `regAddr` |

## Verification
The bench preloads the register model so that every address holds a distinct word. Frames are then sent to both the lowest and the highest address, with data words of all ones, all zeros, alternating bits and set end bits. This shows whether address and data bits are dropped, swapped or shifted.

Read frames and write frames to the same register check two things: that read data appears in the same frame, and that a write frame returns the old value rather than the new one. Frames cut short to 39 edges or stretched to 41 edges, each followed by a read-back, show whether the exact-length rule is applied. The MISO line is sampled during the header bits and between frames to confirm it stays at zero.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 40;
  localparam int HDR_BITS   = 8;
  localparam int ADDR_W     = HDR_BITS - 1;
  localparam int DATA_W     = FRAME_BITS - HDR_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  typedef struct packed {
    logic shiftIn;   // capture one MOSI bit
    logic latchHdr;  // header byte complete, store address and flag
    logic loadRd;    // fetch addressed register into transmit shifter
    logic shiftOut;  // present next read bit on MISO
    logic clear;     // frame idle
    logic commit;    // frame closed with exact length
  } ctrlStrb_t;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csN,
  input  logic mosi,
  output logic sckRise,
  output logic sckFall,
  output logic csHigh,
  output logic csRise,
  output logic mosiS
);
  logic [STAGES-1:0] sckPipe, csPipe, mosiPipe;
  logic sckPrev, csPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPipe  <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sckPipe  <= {sckPipe[STAGES-2:0], sck};
      csPipe   <= {csPipe[STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[STAGES-2:0], mosi};
      sckPrev  <= sckPipe[STAGES-1];
      csPrev   <= csPipe[STAGES-1];
    end
  end

  assign sckRise = sckPipe[STAGES-1] & ~sckPrev;
  assign sckFall = ~sckPipe[STAGES-1] & sckPrev;
  assign csHigh  = csPipe[STAGES-1];
  assign csRise  = csPipe[STAGES-1] & ~csPrev;
  assign mosiS   = mosiPipe[STAGES-1];
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sckRise,
  input  logic             sckFall,
  input  logic             csHigh,
  input  logic             csRise,
  output ctrlStrb_t        strb,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FRAME    = CNT_W'(FRAME_BITS);

  logic latchQ, loadQ;
  logic active;

  assign active = ~csHigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
      latchQ <= 1'b0;
      loadQ  <= 1'b0;
    end else begin
      if (csHigh) bitCnt <= '0;
      else if (sckRise && bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      latchQ <= sckRise & active & (bitCnt == CNT_HDR_LAST);
      loadQ  <= latchQ;
    end
  end

  always_comb begin
    strb.shiftIn  = sckRise & active;
    strb.latchHdr = latchQ;
    strb.loadRd   = loadQ;
    strb.shiftOut = sckFall & active & (bitCnt >= CNT_HDR) & (bitCnt < CNT_FRAME);
    strb.clear    = csHigh;
    strb.commit   = csRise & (bitCnt == CNT_FRAME);
  end
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrb_t         strb,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  output logic              misoQ
);
  logic [DATA_W-1:0] rxShift, txShift;
  logic              wrFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      txShift <= '0;
      regAddr <= '0;
      wrFlag  <= 1'b0;
      misoQ   <= 1'b0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], mosiS};
      if (strb.latchHdr) begin
        regAddr <= rxShift[ADDR_W-1:0];
        wrFlag  <= rxShift[ADDR_W];
      end
      if (strb.clear) begin
        misoQ <= 1'b0;
      end else if (strb.loadRd) begin
        txShift <= regRdata;
      end else if (strb.shiftOut) begin
        misoQ   <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign regWe    = strb.commit & wrFlag;
  assign regWdata = rxShift;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  logic sckRise, sckFall, csHigh, csRise, mosiS, misoQ;
  ctrlStrb_t        strb;
  logic [CNT_W-1:0] bitCnt;

  spi_reg_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csN(csN), .mosi(mosi),
    .sckRise(sckRise), .sckFall(sckFall), .csHigh(csHigh),
    .csRise(csRise), .mosiS(mosiS)
  );

  spi_reg_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .sckRise(sckRise), .sckFall(sckFall),
    .csHigh(csHigh), .csRise(csRise), .strb(strb), .bitCnt(bitCnt)
  );

  spi_reg_dp dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .mosiS(mosiS),
    .regRdata(regRdata), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .misoQ(misoQ)
  );

  assign miso = misoQ & ~csN;

  // R3
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWe |-> bitCnt == CNT_W'(FRAME_BITS));

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWe |=> !regWe);

  // R8
  hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csHigh && bitCnt < CNT_W'(HDR_BITS)) |-> !misoQ);

  // R7
  load_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadRd |-> bitCnt == CNT_W'(HDR_BITS));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csHigh && bitCnt > CNT_W'(HDR_BITS)) |=> $stable(regAddr));
endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;
  localparam int HALF = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [6:0]  regAddr;
  logic        regWe;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  logic [31:0] mem [128];
  int errors = 0;
  int checks = 0;
  logic [38:0] expQ [$];
  bit done = 0;

  always #4 clk = ~clk;

  spi_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csN(csN), .mosi(mosi),
    .miso(miso), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  assign regRdata = mem[regAddr];

  always @(posedge clk) if (regWe) mem[regAddr] <= regWdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every write strobe must match the oldest expected write.
  always @(negedge clk) begin
    if (rst_n && regWe) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4/R5/R6 unexpected write actual=%h:%h expected=none", regAddr, regWdata);
      end else begin
        logic [38:0] e;
        e = expQ.pop_front();
        check("R3 write", {regAddr, regWdata[31:7]}, {e[38:32], e[31:7]});
        check("R3 wdata", regWdata, e[31:0]);
      end
    end
  end

  task automatic frame(input logic wr, input logic [6:0] addr, input logic [31:0] data,
                       input int nbits, input string req);
    logic [39:0] word;
    logic [31:0] expRd, got;
    logic hdrBad;
    word = {wr, addr, data};
    expRd = mem[addr];
    got = '0;
    hdrBad = 1'b0;
    csN = 1'b0;
    repeat (HALF) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 40) ? word[39-i] : 1'b0;
      repeat (HALF) @(posedge clk);
      @(negedge clk);
      if (i < 8 && miso !== 1'b0) hdrBad = 1'b1;
      if (i >= 8 && i < 40) got[39-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(posedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(posedge clk);
    if (wr && nbits == 40) expQ.push_back({addr, data});
    csN = 1'b1;
    repeat (3 * HALF) @(posedge clk);
    if (nbits >= 8) check({"R8 header ", req}, {31'd0, hdrBad}, 32'd0);
    if (nbits >= 40) check({"R7 readback ", req}, got, expRd);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = (i * 32'h01010101) ^ 32'h5A00_00C3;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R10
    check("R10 miso reset", {31'd0, miso}, 32'd0);
    check("R10 we reset", {31'd0, regWe}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);

    // R1 R2 R7: reads from both ends of the address space
    frame(1'b0, 7'h00, 32'h0, 40, "R1 read addr0");
    frame(1'b0, 7'h7F, 32'hFFFF_FFFF, 40, "R2 read addr7f");
    // R3 R7: write returns old value, then read returns new
    frame(1'b1, 7'h7F, 32'hA5A5_5A5A, 40, "R3 write addr7f");
    frame(1'b0, 7'h7F, 32'h0, 40, "R3 read new 7f");
    frame(1'b1, 7'h00, 32'h8000_0001, 40, "R3 write addr0");
    frame(1'b1, 7'h2A, 32'hFFFF_FFFF, 40, "R3 write 2a ones");
    frame(1'b1, 7'h55, 32'h0000_0000, 40, "R3 write 55 zeros");
    frame(1'b0, 7'h00, 32'h0, 40, "R3 read addr0");
    frame(1'b0, 7'h2A, 32'h0, 40, "R1 read 2a");
    // R6: read with all-ones data field writes nothing
    frame(1'b0, 7'h13, 32'hFFFF_FFFF, 40, "R6 read 13");
    frame(1'b0, 7'h13, 32'h0, 40, "R6 readback 13");
    // R4: short frame discarded
    frame(1'b1, 7'h21, 32'h1234_5678, 39, "R4 short");
    frame(1'b0, 7'h21, 32'h0, 40, "R4 readback 21");
    // R5: overrun frame discarded
    frame(1'b1, 7'h22, 32'hCAFE_F00D, 41, "R5 long");
    frame(1'b0, 7'h22, 32'h0, 40, "R5 readback 22");
    // R9: idle line
    @(negedge clk);
    check("R9 idle miso", {31'd0, miso}, 32'd0);
    check("R3 pending writes", expQ.size(), 32'd0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule